// File: doc/BRIEF.md
# Module Clock Gating Controller

This block is a central clock-gating controller for a small system-on-chip with fourteen peripheral modules. Each module gets two gated copies of the system clock. The functional clock drives the module's working logic and stops when software sets that module's disable bit. The register clock drives the module's register file and runs in any cycle in which the bus is addressing that module, whether or not the module is disabled. Every gate is a clock-enable latch that is transparent while the clock is low, followed by an AND with the clock. An enable change can therefore only show up at the start of a high phase, and the gate cannot produce a runt pulse.

Two further gated clocks are provided. The trace-port clock has an enable bit and an auto-gate bit. When both are set, the trace clock runs only while trace messages are pending. The memory-array clock stops through its own stop bit. A stop request is held back while a memory access is outstanding and takes effect once the memory goes idle.

Software controls the block through a small register bus. It can read back the actual gating state of every clock, and all clocks come out of reset running.

Top module: `cg_ctrl`

## Requirements
- R1: After reset, all disable bits (address 0) read 0, the trace control (address 1) reads 1 (bit0 enable = 1, bit1 auto-gate = 0), and the stop bit (address 2) reads 0. Functional status (address 3) reads all ones, and every func_clk, trace_clk and mem_clk pulses high in each clock high phase.
- R2: Writing address 0 loads the disable bits, with bit i belonging to module i. From the high phase after the second rising edge following the write edge, func_clk[i] is held low where the bit is 1 and pulses where it is 0. Status address 3 bit i reads 1 exactly when func_clk[i] is running.
- R3: reg_clk[i] pulses in a high phase when mod_sel[i] or mod_busy[i] was high before the rising edge that starts that phase. Otherwise it stays low. This does not depend on the disable bit of module i.
- R4: trace_clk follows the value of en & (~gate | trace_pending), where en and gate are the address 1 bits. If en is 0, trace_clk stays low even with messages pending. A change of trace_pending before a rising edge shows up in the high phase after the next rising edge. A register write takes effect with the timing of R2.
- R5: Address 2 bit0 requests a memory stop. mem_clk stops once the request is set and mem_busy is low at a rising edge; it goes low from the high phase after the next rising edge. While mem_busy stays high, mem_clk keeps running. Clearing the bit restarts mem_clk with the timing of R2.
- R6: Address 4 is read-only. Bit0 reads 1 while trace_clk is running, and bit1 reads 1 while the memory clock is stopped.
- R7: bus_ack rises in the cycle after an accepted bus_valid, and bus_rdata is valid in that same cycle. Addresses 5 to 7 read 0, and writes to them change no register. Addresses 3 and 4 cannot be written.
- R8: No gated clock output is ever high while clk is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_ack | output | 1 | Access complete, one cycle after the request |
| mod_sel | input | 14 | Per-module bus select for the coming data phase |
| mod_busy | input | 14 | Per-module access still in progress |
| trace_pending | input | 1 | Trace messages are queued |
| mem_busy | input | 1 | Memory access outstanding |
| func_clk | output | 14 | Gated functional clocks |
| reg_clk | output | 14 | Gated register-domain clocks |
| trace_clk | output | 1 | Gated trace-port clock |
| mem_clk | output | 1 | Gated memory-array clock |

## Verification
Suppose a disable or enable flop holds the wrong value. The affected gated clock then stays low, or keeps pulsing, from the second high phase after the write, and the status registers show the same error on the next read. A stop request that fails to defer shows up within one cycle as a missing mem_clk pulse while mem_busy is high. A register-clock enable that fails to follow the bus select shows up in the very high phase that should have carried the pulse.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_DIS  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TRC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STOP = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_MISC = 3'd4;
endpackage

// File: rtl/cg_icg.sv
module cg_icg (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_l;

  // enable captured only while clk is low: edges of gclk follow clk
  always_latch begin
    if (!clk) en_l = en;
  end

  assign gclk = clk & en_l;

  // R8: gated clock never high during low phase
  always_comb begin
    if (!clk) assert (!gclk) else $error("p_no_low_pulse_r8");
  end
endmodule

// File: rtl/cg_regs.sv
module cg_regs
  import cg_pkg::*;
#(
  parameter int N  = 14,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [N-1:0]      func_on,
  input  logic              trace_on,
  input  logic              mem_stopped,
  output logic [N-1:0]      dis,
  output logic              trc_en,
  output logic              trc_gate,
  output logic              stop_req,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack
);
  logic [DW-1:0] rd_n;
  logic          unused_wdata;
  logic          wr;

  assign unused_wdata = ^bus_wdata;
  assign wr = bus_valid & bus_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis      <= '0;
      trc_en   <= 1'b1;
      trc_gate <= 1'b0;
      stop_req <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        A_DIS:   dis <= bus_wdata[N-1:0];
        A_TRC:   begin trc_en <= bus_wdata[0]; trc_gate <= bus_wdata[1]; end
        A_STOP:  stop_req <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_n = '0;
    case (bus_addr)
      A_DIS:   rd_n[N-1:0] = dis;
      A_TRC:   rd_n[1:0]   = {trc_gate, trc_en};
      A_STOP:  rd_n[0]     = stop_req;
      A_STAT:  rd_n[N-1:0] = func_on;
      A_MISC:  rd_n[1:0]   = {mem_stopped, trace_on};
      default: rd_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_ack   <= 1'b0;
    end else begin
      bus_ack <= bus_valid;
      if (bus_valid && !bus_we) bus_rdata <= rd_n;
    end
  end

  p_ack_follows_r7: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> bus_ack);
  p_ack_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !bus_ack);
endmodule

// File: rtl/cg_enables.sv
module cg_enables #(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] dis,
  input  logic         trc_en,
  input  logic         trc_gate,
  input  logic         trace_pending,
  output logic [N-1:0] func_on,
  output logic         trace_on
);
  always_ff @(posedge clk) begin
    if (rst) begin
      func_on  <= '1;
      trace_on <= 1'b1;
    end else begin
      func_on  <= ~dis;
      trace_on <= trc_en & (~trc_gate | trace_pending);
    end
  end

  p_reset_on_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (func_on == '1 && trace_on));
  p_trace_off_r4: assert property (@(posedge clk) disable iff (rst)
    !trc_en |=> !trace_on);
  p_trace_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (trc_en && trc_gate && !trace_pending) |=> !trace_on);
endmodule

// File: rtl/cg_mem_stop.sv
module cg_mem_stop (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic mem_busy,
  output logic stopped
);
  always_ff @(posedge clk) begin
    if (rst)                       stopped <= 1'b0;
    else if (!stop_req)            stopped <= 1'b0;
    else if (!mem_busy)            stopped <= 1'b1;
  end

  p_defer_r5: assert property (@(posedge clk) disable iff (rst)
    (!stopped && mem_busy) |=> !stopped);
  p_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !stop_req |=> !stopped);
endmodule

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
#(
  parameter int N  = 14,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_ack,
  input  logic [N-1:0]      mod_sel,
  input  logic [N-1:0]      mod_busy,
  input  logic              trace_pending,
  input  logic              mem_busy,
  output logic [N-1:0]      func_clk,
  output logic [N-1:0]      reg_clk,
  output logic              trace_clk,
  output logic              mem_clk
);
  logic [N-1:0] dis, func_on;
  logic         trc_en, trc_gate, stop_req, trace_on, mem_stopped;
  logic         wr_dis;

  cg_regs #(.N(N), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .func_on(func_on),
    .trace_on(trace_on), .mem_stopped(mem_stopped), .dis(dis),
    .trc_en(trc_en), .trc_gate(trc_gate), .stop_req(stop_req),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  cg_enables #(.N(N)) u_en (
    .clk(clk), .rst(rst), .dis(dis), .trc_en(trc_en), .trc_gate(trc_gate),
    .trace_pending(trace_pending), .func_on(func_on), .trace_on(trace_on)
  );

  cg_mem_stop u_mem (
    .clk(clk), .rst(rst), .stop_req(stop_req), .mem_busy(mem_busy),
    .stopped(mem_stopped)
  );

  for (genvar i = 0; i < N; i++) begin : g_mod
    cg_icg u_func (.clk(clk), .en(func_on[i]), .gclk(func_clk[i]));
    cg_icg u_reg  (.clk(clk), .en(mod_sel[i] | mod_busy[i]), .gclk(reg_clk[i]));
  end

  cg_icg u_trace (.clk(clk), .en(trace_on),     .gclk(trace_clk));
  cg_icg u_memck (.clk(clk), .en(!mem_stopped), .gclk(mem_clk));

  assign wr_dis = bus_valid & bus_we & (bus_addr == A_DIS);

  p_dis_latency_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_dis, 2) && !$past(rst, 2) && !$past(rst) && !$past(wr_dis))
      |-> (func_on == ~$past(bus_wdata[N-1:0], 2)));
endmodule

// File: tb/tb_cg_ctrl.sv
module tb_cg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 14;
  localparam int DW = 16;
  localparam int NV = 6;
  // {disable pattern, expected running-clock mask}
  localparam logic [2*N-1:0] VEC [NV] = '{
    {14'h0001, 14'h3FFE}, {14'h2000, 14'h1FFF}, {14'h1555, 14'h2AAA},
    {14'h2AAA, 14'h1555}, {14'h3FFF, 14'h0000}, {14'h0000, 14'h3FFF}
  };

  logic clk = 0, rst = 1;
  logic bus_valid = 0, bus_we = 0;
  logic [2:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0, bus_rdata;
  logic bus_ack;
  logic [N-1:0] mod_sel = 0, mod_busy = 0, func_clk, reg_clk;
  logic trace_pending = 0, mem_busy = 0, trace_clk, mem_clk;
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  cg_ctrl #(.N(N), .DW(DW)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .mod_sel(mod_sel), .mod_busy(mod_busy),
    .trace_pending(trace_pending), .mem_busy(mem_busy), .func_clk(func_clk),
    .reg_clk(reg_clk), .trace_clk(trace_clk), .mem_clk(mem_clk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_valid = 0; bus_we = 0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk); bus_valid = 1; bus_we = 0; bus_addr = a;
    @(posedge clk); #2;
    check("R7 ack", {31'b0, bus_ack}, 32'd1);
    d = bus_rdata;
    @(negedge clk); bus_valid = 0;
  endtask

  task automatic hi2;   // high phase after second rising edge
    @(posedge clk); @(posedge clk); #2;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(posedge clk); #2;
    check("R1 func_clk", {18'b0, func_clk}, 32'h3FFF);
    check("R1 trace/mem clk", {30'b0, trace_clk, mem_clk}, 32'd3);
    rdreg(3'd0, rd); check("R1 dis", {16'b0, rd}, 0);
    rdreg(3'd1, rd); check("R1 trc", {16'b0, rd}, 1);
    rdreg(3'd2, rd); check("R1 stop", {16'b0, rd}, 0);
    rdreg(3'd3, rd); check("R1 status", {16'b0, rd}, 32'h3FFF);

    for (int v = 0; v < NV; v++) begin
      wr(3'd0, {2'b0, VEC[v][2*N-1:N]});
      hi2;
      check("R2 func_clk", {18'b0, func_clk}, {18'b0, VEC[v][N-1:0]});
      @(negedge clk); #2;
      check("R8 low phase", {16'b0, func_clk, trace_clk, mem_clk}, 0);
      rdreg(3'd3, rd);
      check("R2 status", {16'b0, rd}, {18'b0, VEC[v][N-1:0]});
    end

    // R3 register clock with module disabled
    wr(3'd0, 16'h3FFF); hi2;
    @(negedge clk); mod_sel = 14'h0008;
    @(posedge clk); #2;
    check("R3 sel", {18'b0, reg_clk}, 32'h0008);
    check("R3 func off", {18'b0, func_clk}, 0);
    @(negedge clk); mod_sel = 0; mod_busy = 14'h0008;
    @(posedge clk); #2;
    check("R3 busy", {18'b0, reg_clk}, 32'h0008);
    @(negedge clk); mod_busy = 0;
    @(posedge clk); #2;
    check("R3 idle", {18'b0, reg_clk}, 0);

    // R4 trace gating
    wr(3'd1, 16'h0000);
    @(negedge clk); trace_pending = 1;
    hi2;
    check("R4 en=0", {31'b0, trace_clk}, 0);
    @(negedge clk); trace_pending = 0;
    wr(3'd1, 16'h0003); hi2;
    check("R4 gated idle", {31'b0, trace_clk}, 0);
    rdreg(3'd4, rd); check("R6 trace off", {16'b0, rd}, 0);
    @(negedge clk); trace_pending = 1;
    hi2;
    check("R4 pending", {31'b0, trace_clk}, 1);
    rdreg(3'd4, rd); check("R6 trace on", {16'b0, rd}, 1);
    @(negedge clk); trace_pending = 0;
    wr(3'd1, 16'h0001); hi2;
    check("R4 free run", {31'b0, trace_clk}, 1);

    // R5 memory stop deferral
    @(negedge clk); mem_busy = 1;
    wr(3'd2, 16'h0001);
    repeat (3) @(posedge clk); #2;
    check("R5 deferred", {31'b0, mem_clk}, 1);
    rdreg(3'd4, rd); check("R6 mem running", {16'b0, rd}, 1);
    @(negedge clk); mem_busy = 0;
    hi2;
    check("R5 stopped", {31'b0, mem_clk}, 0);
    rdreg(3'd4, rd); check("R6 mem stopped", {16'b0, rd}, 3);
    wr(3'd2, 16'h0000); hi2;
    check("R5 restart", {31'b0, mem_clk}, 1);

    // R7 unmapped and read-only addresses
    wr(3'd0, 16'h0055);
    wr(3'd7, 16'hFFFF);
    wr(3'd3, 16'h0000);
    rdreg(3'd0, rd); check("R7 ignored write", {16'b0, rd}, 32'h0055);
    rdreg(3'd7, rd); check("R7 unmapped read", {16'b0, rd}, 0);
    rdreg(3'd3, rd); check("R7 status ro", {16'b0, rd}, 32'h3FAA);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule